// File: doc/BRIEF.md
# Bandwidth Slot Allocation Engine

This engine builds the contents of a 64-entry time-slot table for a memory arbiter. Each entry names the client that owns that slot. A start strobe samples a per-client array of requested slot counts, an active-client bitmap and a count of spare slots. The engine then places clients into a private copy of the table. Clients that asked for slots go in at evenly spaced positions. Active clients that asked for none get one spare slot each while spares remain. Every position still empty is then handed out round-robin over the active clients. Each final entry is streamed to the table write port in slot order, and a done pulse closes the pass.

The same engine has a second job. It turns a bandwidth figure into a slot count by two successive integer divisions. It then checks that count against the number of slots already promised. The result is a one-cycle accept or reject pulse, and the table is never written on this path. Both jobs share one iterative divider. The engine serves one command at a time.

The controller has nine states. ST_IDLE waits for a command. ST_PICK looks at one client. ST_DIV waits for that client's stride. ST_WALK places the client. ST_SWEEP fills and emits each slot. ST_DONE pulses completion. ST_BWDIV and ST_SLOTDIV run the two divisions of a bandwidth request, and ST_JUDGE gives the verdict.

The transitions are:
- ST_IDLE goes to ST_PICK on start. On a request it goes to ST_BWDIV, or straight to ST_JUDGE when the bandwidth is zero.
- ST_PICK goes to ST_DIV for a nonzero count. It goes to ST_WALK for a spare-slot grant. For a skipped client it stays in ST_PICK, or moves to ST_SWEEP after the last client.
- ST_DIV goes to ST_WALK when the divider finishes.
- ST_WALK goes back to ST_PICK when the walk passes slot 63, or to ST_SWEEP after the last client.
- ST_SWEEP goes to ST_DONE after slot 63.
- ST_DONE goes to ST_IDLE.
- ST_BWDIV goes to ST_SLOTDIV, or to ST_JUDGE when its quotient is zero.
- ST_SLOTDIV goes to ST_JUDGE.
- ST_JUDGE goes to ST_IDLE.

Top module: `slot_alloc_engine`

## Requirements
- R1: After reset, busy_o, wr_en_o, done_o, req_ok_o and req_err_o are all low.
- R2: A fill emits exactly 64 writes on consecutive cycles, with wr_idx_o running 0,1,...,63. done_o is high for one cycle, in the cycle right after the write of slot 63, and busy_o is low in the cycle after that.
- R3: Clients are placed in ascending index order. Each client with a nonzero count N uses stride floor(64/N). Its walk starts at position 0. An occupied position moves the walk on by one. A free position is given to the client and the walk then jumps ahead by the stride. The walk ends once it passes 63. A client placed earlier keeps its positions.
- R4: An active client with a zero count receives exactly one slot, at the first free position, only while the sampled spare counter is above zero. Each such grant lowers the counter by one.
- R5: An inactive client with a zero count receives nothing during placement. A client with a nonzero count is placed whether or not it is active.
- R6: After placement, each still-empty position, in slot order, receives the first active client found at or after a rotating pointer (searching cyclically over 0..14). The pointer starts at 0 for each fill and moves to one past the chosen client. Positions already occupied do not move the pointer.
- R7: When no client is active, an empty position receives the pointer value itself, and the pointer still advances by one (modulo 15).
- R8: Every written entry is a valid client index in 0..14. The internal empty marker is never written.
- R9: start_i and req_go_i are ignored while busy_o is high. When both are high in an idle cycle, the fill runs and the request is dropped.
- R10: The slot count of a request is 0 when the bandwidth is 0. Otherwise it is floor(64 / q), where q = floor(400000000 / bandwidth). A quotient q of 0 gives 64.
- R11: A request ends with exactly one one-cycle pulse. The pulse is req_err_o when req_total_i plus the slot count exceeds 64, and req_ok_o otherwise. req_slots_o holds the count during the pulse, and the table is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a table fill (sampled in ST_IDLE) |
| cnt_i | input | 105 | Requested slot counts, 7 bits per client, client c at bits [7c+6:7c] |
| active_i | input | 15 | Active-client bitmap, bit c for client c |
| unused_i | input | 7 | Number of spare slots for zero-count active clients |
| req_go_i | input | 1 | Start a bandwidth request |
| req_bw_i | input | 32 | Requested bandwidth |
| req_total_i | input | 7 | Slots already assigned |
| busy_o | output | 1 | Engine is not idle |
| wr_en_o | output | 1 | Table write strobe |
| wr_idx_o | output | 6 | Slot index being written |
| wr_data_o | output | 4 | Client index for that slot |
| done_o | output | 1 | One-cycle end-of-fill pulse |
| req_ok_o | output | 1 | Request accepted pulse |
| req_err_o | output | 1 | Request rejected pulse |
| req_slots_o | output | 7 | Slot count of the request |

## Verification
The bench goes after several corner cases. One is collisions between strides, where a later client lands on occupied positions. A design that jumped by the stride instead of stepping by one would shift or drop that client's slots. Another is spare slots running out partway through the zero-count clients. A design that ignored the counter would give the last clients a slot they should only get round-robin. A third is the no-active-client fill. A design that froze the pointer or wrote the empty marker would emit a constant value or an out-of-range index. Bandwidth requests are checked at zero, above the maximum, at tiny values whose count floors to zero, and exactly at the 64-slot limit. An off-by-one in the overcommit compare or the second division changes the accept or reject verdict. Commands issued while busy must leave the write stream untouched.

// File: rtl/slot_alloc_pkg.sv
`timescale 1ns/1ps
package slot_alloc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PICK,
        ST_DIV,
        ST_WALK,
        ST_SWEEP,
        ST_DONE,
        ST_BWDIV,
        ST_SLOTDIV,
        ST_JUDGE
    } eng_state_e;

endpackage

// File: rtl/slot_seq_div.sv
`timescale 1ns/1ps
// Restoring divider, one quotient bit per cycle; a zero divisor yields all ones.
module slot_seq_div #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         done_o,
    output logic [W-1:0] quo_o
);
    localparam int unsigned CNTW = $clog2(W + 1);

    logic [W-1:0]    rem_q, quo_q, den_q;
    logic [CNTW-1:0] left_q;
    logic            done_q;
    logic [W:0]      shifted, diff;
    logic            ge;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, den_q};
        ge      = !diff[W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            left_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i) begin
                rem_q  <= '0;
                quo_q  <= num_i;
                den_q  <= den_i;
                left_q <= CNTW'(W);
            end else if (left_q != '0) begin
                rem_q  <= ge ? diff[W-1:0] : shifted[W-1:0];
                quo_q  <= {quo_q[W-2:0], ge};
                left_q <= left_q - 1'b1;
                if (left_q == CNTW'(1)) done_q <= 1'b1;
            end
        end
    end

    assign done_o = done_q;
    assign quo_o  = quo_q;
endmodule

// File: rtl/slot_rr_pick.sv
`timescale 1ns/1ps
// Cyclic search for the first set bit at or after base.
module slot_rr_pick #(
    parameter int unsigned NCLI = 15,
    parameter int unsigned CW   = 4
) (
    input  logic [NCLI-1:0] act_i,
    input  logic [CW-1:0]   base_i,
    output logic            found_o,
    output logic [CW-1:0]   idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = base_i;
        for (int k = 0; k < NCLI; k++) begin
            logic [CW:0] c;
            c = {1'b0, base_i} + (CW+1)'(k);
            if (c >= (CW+1)'(NCLI)) c = c - (CW+1)'(NCLI);
            if (!found_o && act_i[c[CW-1:0]]) begin
                found_o = 1'b1;
                idx_o   = c[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/slot_alloc_engine.sv
`timescale 1ns/1ps
module slot_alloc_engine
    import slot_alloc_pkg::*;
#(
    parameter int unsigned NCLI    = 15,
    parameter int unsigned NSLOT   = 64,
    parameter int unsigned BWW     = 32,
    parameter int unsigned BW_FULL = 400000000,
    localparam int unsigned CW     = $clog2(NCLI + 1),
    localparam int unsigned SW     = $clog2(NSLOT),
    localparam int unsigned NW     = SW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NCLI*NW-1:0] cnt_i,
    input  logic [NCLI-1:0]   active_i,
    input  logic [NW-1:0]     unused_i,
    input  logic              req_go_i,
    input  logic [BWW-1:0]    req_bw_i,
    input  logic [NW-1:0]     req_total_i,
    output logic              busy_o,
    output logic              wr_en_o,
    output logic [SW-1:0]     wr_idx_o,
    output logic [CW-1:0]     wr_data_o,
    output logic              done_o,
    output logic              req_ok_o,
    output logic              req_err_o,
    output logic [NW-1:0]     req_slots_o
);
    localparam int unsigned PW   = SW + 2;
    localparam logic [CW-1:0] SENT = CW'(NCLI);
    localparam logic [CW-1:0] LAST = CW'(NCLI - 1);

    eng_state_e st_q, st_d;

    logic [NW-1:0]   cnt_in [NCLI];
    logic [NW-1:0]   cnt_q  [NCLI];
    logic [CW-1:0]   vec_q  [NSLOT];
    logic [NCLI-1:0] act_q;
    logic [NW-1:0]   spare_q;
    logic [CW-1:0]   cli_q;
    logic [PW-1:0]   pos_q;
    logic [NW-1:0]   stride_q;
    logic [SW-1:0]   slot_q;
    logic [CW-1:0]   rr_q;
    logic [NW-1:0]   tot_q, slots_q;

    logic            div_go, div_done;
    logic [BWW-1:0]  div_num, div_den, div_quo;

    logic [NW-1:0]   cur_cnt;
    logic            last_cli, walk_end, pos_busy;
    logic [CW-1:0]   cur_ent, fill_val, next_rr, rr_idx;
    logic            rr_found, slot_taken, over;

    for (genvar g = 0; g < NCLI; g++) begin : g_unpack
        assign cnt_in[g] = cnt_i[g*NW +: NW];
    end

    assign cur_cnt    = cnt_q[cli_q];
    assign last_cli   = (cli_q == LAST);
    assign walk_end   = (pos_q >= PW'(NSLOT));
    assign pos_busy   = (vec_q[pos_q[SW-1:0]] != SENT);
    assign cur_ent    = vec_q[slot_q];
    assign slot_taken = (cur_ent != SENT);
    assign fill_val   = rr_found ? rr_idx : rr_q;
    assign next_rr    = (fill_val == LAST) ? '0 : fill_val + 1'b1;
    assign over       = ({1'b0, tot_q} + {1'b0, slots_q}) > (NW+1)'(NSLOT);

    slot_rr_pick #(.NCLI(NCLI), .CW(CW)) u_pick (
        .act_i   (act_q),
        .base_i  (rr_q),
        .found_o (rr_found),
        .idx_o   (rr_idx)
    );

    slot_seq_div #(.W(BWW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (div_go),
        .num_i  (div_num),
        .den_i  (div_den),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    // Divider launch and operand selection
    always_comb begin
        div_go  = 1'b0;
        div_num = BWW'(NSLOT);
        div_den = BWW'(cur_cnt);
        unique case (st_q)
            ST_IDLE: begin
                div_num = BWW'(BW_FULL);
                div_den = req_bw_i;
                div_go  = !start_i && req_go_i && (req_bw_i != '0);
            end
            ST_PICK:  div_go = (cur_cnt != '0);
            ST_BWDIV: begin
                div_den = div_quo;
                div_go  = div_done && (div_quo != '0);
            end
            default: ;
        endcase
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i)       st_d = ST_PICK;
                else if (req_go_i) st_d = (req_bw_i == '0) ? ST_JUDGE : ST_BWDIV;
            end
            ST_PICK: begin
                if (cur_cnt != '0)                      st_d = ST_DIV;
                else if (act_q[cli_q] && spare_q != '0) st_d = ST_WALK;
                else if (last_cli)                      st_d = ST_SWEEP;
            end
            ST_DIV:     if (div_done) st_d = ST_WALK;
            ST_WALK:    if (walk_end) st_d = last_cli ? ST_SWEEP : ST_PICK;
            ST_SWEEP:   if (slot_q == SW'(NSLOT - 1)) st_d = ST_DONE;
            ST_DONE:    st_d = ST_IDLE;
            ST_BWDIV:   if (div_done) st_d = (div_quo == '0) ? ST_JUDGE : ST_SLOTDIV;
            ST_SLOTDIV: if (div_done) st_d = ST_JUDGE;
            ST_JUDGE:   st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCLI; i++)  cnt_q[i] <= '0;
            for (int s = 0; s < NSLOT; s++) vec_q[s] <= SENT;
            act_q    <= '0;
            spare_q  <= '0;
            cli_q    <= '0;
            pos_q    <= '0;
            stride_q <= '0;
            slot_q   <= '0;
            rr_q     <= '0;
            tot_q    <= '0;
            slots_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        for (int i = 0; i < NCLI; i++)  cnt_q[i] <= cnt_in[i];
                        for (int s = 0; s < NSLOT; s++) vec_q[s] <= SENT;
                        act_q   <= active_i;
                        spare_q <= unused_i;
                        cli_q   <= '0;
                        slot_q  <= '0;
                        rr_q    <= '0;
                    end else if (req_go_i) begin
                        tot_q   <= req_total_i;
                        slots_q <= '0;
                    end
                end
                ST_PICK: begin
                    if (cur_cnt != '0) begin
                        pos_q <= '0;
                    end else if (act_q[cli_q] && spare_q != '0) begin
                        spare_q  <= spare_q - 1'b1;
                        stride_q <= NW'(NSLOT);
                        pos_q    <= '0;
                    end else if (!last_cli) begin
                        cli_q <= cli_q + 1'b1;
                    end
                end
                ST_DIV: begin
                    if (div_done) stride_q <= div_quo[NW-1:0];
                end
                ST_WALK: begin
                    if (walk_end) begin
                        if (!last_cli) cli_q <= cli_q + 1'b1;
                    end else if (pos_busy) begin
                        pos_q <= pos_q + 1'b1;
                    end else begin
                        vec_q[pos_q[SW-1:0]] <= cli_q;
                        pos_q <= pos_q + PW'(stride_q);
                    end
                end
                ST_SWEEP: begin
                    if (!slot_taken) rr_q <= next_rr;
                    slot_q <= slot_q + 1'b1;
                end
                ST_BWDIV: begin
                    if (div_done && div_quo == '0) slots_q <= NW'(NSLOT);
                end
                ST_SLOTDIV: begin
                    if (div_done) slots_q <= div_quo[NW-1:0];
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o      = (st_q != ST_IDLE);
        wr_en_o     = (st_q == ST_SWEEP);
        wr_idx_o    = slot_q;
        wr_data_o   = slot_taken ? cur_ent : fill_val;
        done_o      = (st_q == ST_DONE);
        req_ok_o    = (st_q == ST_JUDGE) && !over;
        req_err_o   = (st_q == ST_JUDGE) && over;
        req_slots_o = slots_q;
    end
endmodule

// File: rtl/slot_alloc_chk.sv
`timescale 1ns/1ps
module slot_alloc_chk #(
    parameter int unsigned NCLI  = 15,
    parameter int unsigned NSLOT = 64,
    localparam int unsigned CW   = $clog2(NCLI + 1),
    localparam int unsigned SW   = $clog2(NSLOT)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          wr_en,
    input logic [SW-1:0] wr_idx,
    input logic [CW-1:0] wr_data,
    input logic          done,
    input logic          req_ok,
    input logic          req_err
);
    // R2
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_idx == SW'($past(wr_idx) + 1'b1)));

    // R2
    first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> (wr_idx == '0));

    // R2
    last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == SW'(NSLOT - 1)) |=> (done && !wr_en));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8
    client_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data < CW'(NCLI)));

    // R11
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ok |-> !req_err);
endmodule

bind slot_alloc_engine slot_alloc_chk #(.NCLI(NCLI), .NSLOT(NSLOT)) u_slot_alloc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_o),
    .wr_en   (wr_en_o),
    .wr_idx  (wr_idx_o),
    .wr_data (wr_data_o),
    .done    (done_o),
    .req_ok  (req_ok_o),
    .req_err (req_err_o)
);

// File: tb/slot_alloc_engine_bench.sv
`timescale 1ns/1ps
module slot_alloc_engine_bench;
    localparam int NCLI = 15;
    localparam int NSLOT = 64;
    localparam int NW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NCLI*NW-1:0] cnt_flat = '0;
    logic [NCLI-1:0] act = '0;
    logic [NW-1:0] unused = '0;
    logic req_go = 1'b0;
    logic [31:0] req_bw = '0;
    logic [NW-1:0] req_total = '0;
    logic busy, wr_en, done, req_ok, req_err;
    logic [5:0] wr_idx;
    logic [3:0] wr_data;
    logic [NW-1:0] req_slots;

    always #2.5 clk = ~clk;

    slot_alloc_engine u_slot_alloc_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cnt_i(cnt_flat),
        .active_i(act), .unused_i(unused), .req_go_i(req_go),
        .req_bw_i(req_bw), .req_total_i(req_total), .busy_o(busy),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
        .done_o(done), .req_ok_o(req_ok), .req_err_o(req_err),
        .req_slots_o(req_slots)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int exp_idx_q[$];
    int exp_dat_q[$];
    bit req_pend = 0;
    bit exp_ok = 0;
    int exp_slots = 0;
    string cur_tag = "R2";

    int m_cnt[NCLI];
    bit m_act[NCLI];
    int m_unused;

    task automatic chk(input bit good, input string tag, input string what,
                       input longint actv, input longint expv);
        n_cmp++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, actv, expv);
        end
    endtask

    // Behavioural expectation of one fill, pushed as (slot, client) pairs
    function automatic void model_fill();
        int v[NSLOT];
        int un, iv, p, rr, first;
        un = m_unused;
        foreach (v[s]) v[s] = -1;
        for (int c = 0; c < NCLI; c++) begin
            if (m_cnt[c] == 0) begin
                if (!m_act[c] || un <= 0) continue;
                un--;
                iv = NSLOT;
            end else begin
                iv = NSLOT / m_cnt[c];
            end
            p = 0;
            while (p < NSLOT) begin
                if (v[p] >= 0) p++;
                else begin v[p] = c; p += iv; end
            end
        end
        rr = 0;
        for (int s = 0; s < NSLOT; s++) begin
            if (v[s] < 0) begin
                first = rr;
                while (!m_act[rr]) begin
                    rr = (rr + 1) % NCLI;
                    if (rr == first) break;
                end
                v[s] = rr;
                rr = (rr + 1) % NCLI;
            end
            exp_idx_q.push_back(s);
            exp_dat_q.push_back(v[s]);
        end
    endfunction

    function automatic void load_inputs();
        for (int c = 0; c < NCLI; c++) begin
            cnt_flat[c*NW +: NW] = NW'(m_cnt[c]);
            act[c] = m_act[c];
        end
        unused = NW'(m_unused);
    endfunction

    function automatic void clear_model();
        for (int c = 0; c < NCLI; c++) begin m_cnt[c] = 0; m_act[c] = 0; end
        m_unused = 0;
    endfunction

    // Per-clock comparison against the expectation queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (exp_idx_q.size() == 0) begin
                    chk(0, "R11", "unexpected table write", wr_idx, -1);
                end else begin
                    int ei, ed;
                    ei = exp_idx_q.pop_front();
                    ed = exp_dat_q.pop_front();
                    chk(wr_idx == ei, "R2", "write slot order", wr_idx, ei);
                    chk(wr_data == ed, cur_tag, $sformatf("client of slot %0d", ei), wr_data, ed);
                end
                chk(wr_data < NCLI, "R8", "client index range", wr_data, NCLI - 1);
            end
            if (done) begin
                chk(exp_idx_q.size() == 0, "R2", "done before all slots", exp_idx_q.size(), 0);
                done_cnt++;
            end
            if (req_ok || req_err) begin
                if (!req_pend) begin
                    chk(0, "R9", "unexpected request verdict", req_ok, 0);
                end else begin
                    chk(req_ok == exp_ok && req_err == !exp_ok, "R11", "verdict ok", req_ok, exp_ok);
                    chk(req_slots == exp_slots, "R10", "slot count", req_slots, exp_slots);
                    req_pend = 0;
                end
            end
        end
    end

    task automatic do_fill(input string tag);
        int d0;
        cur_tag = tag;
        load_inputs();
        model_fill();
        d0 = done_cnt;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        while (done_cnt == d0) @(posedge clk);
        @(posedge clk); #1;
    endtask

    task automatic do_req(input longint bw, input int total);
        longint q;
        if (bw == 0) exp_slots = 0;
        else begin
            q = 400000000 / bw;
            exp_slots = (q == 0) ? 64 : int'(64 / q);
        end
        exp_ok = (total + exp_slots) <= 64;
        req_pend = 1;
        req_bw = 32'(bw);
        req_total = NW'(total);
        @(posedge clk); #1 req_go = 1'b1;
        @(posedge clk); #1 req_go = 1'b0;
        while (req_pend) @(posedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R2", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(!busy && !wr_en && !done, "R1", "fill outputs idle", {busy, wr_en, done}, 0);
        chk(!req_ok && !req_err, "R1", "request outputs idle", {req_ok, req_err}, 0);

        // R7: nothing active, pointer value itself used
        clear_model();
        do_fill("R7");

        // R3: stride placement with collisions
        clear_model();
        m_cnt[0] = 4; m_cnt[1] = 2; m_cnt[2] = 8; m_cnt[6] = 3;
        m_act[0] = 1; m_act[1] = 1; m_act[2] = 1; m_act[6] = 1;
        do_fill("R3");

        // R3: full-table client shadows later clients
        clear_model();
        m_cnt[0] = 64; m_cnt[1] = 32; m_act[1] = 1;
        do_fill("R3");

        // R4: spare counter runs out before client 12
        clear_model();
        m_cnt[0] = 16; m_act[0] = 1; m_act[5] = 1; m_act[11] = 1; m_act[12] = 1;
        m_unused = 2;
        do_fill("R4");

        // R5: inactive zero-count skipped, inactive nonzero placed
        clear_model();
        m_cnt[7] = 2; m_act[3] = 1; m_unused = 5;
        do_fill("R5");

        // R6: pure round-robin over sparse active set
        clear_model();
        m_act[2] = 1; m_act[9] = 1; m_act[14] = 1;
        do_fill("R6");

        // R6: round-robin skipping over placed entries
        clear_model();
        m_cnt[4] = 5; m_cnt[13] = 1; m_act[4] = 1; m_act[10] = 1; m_act[13] = 1;
        do_fill("R6");

        // R9: start and request while busy are ignored
        clear_model();
        m_cnt[1] = 8; m_act[1] = 1; m_act[3] = 1;
        cur_tag = "R9";
        load_inputs();
        model_fill();
        begin
            int d0;
            d0 = done_cnt;
            @(posedge clk); #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
            repeat (20) @(posedge clk);
            #1 cnt_flat = '0; act = 15'h7FFF; start = 1'b1; req_go = 1'b1; req_bw = 32'd100000000;
            @(posedge clk); #1 start = 1'b0; req_go = 1'b0;
            while (done_cnt == d0) @(posedge clk);
        end
        repeat (80) @(posedge clk);
        @(negedge clk);
        chk(!busy, "R9", "engine idle after ignored commands", busy, 0);

        // R9: start wins over simultaneous request
        clear_model();
        m_act[0] = 1; m_act[8] = 1;
        cur_tag = "R9";
        load_inputs();
        model_fill();
        begin
            int d0;
            d0 = done_cnt;
            @(posedge clk); #1 start = 1'b1; req_go = 1'b1; req_bw = 32'd50000000;
            @(posedge clk); #1 start = 1'b0; req_go = 1'b0;
            while (done_cnt == d0) @(posedge clk);
        end
        repeat (60) @(posedge clk);

        // R10, R11: conversion and overcommit check
        do_req(0, 0);
        do_req(100000000, 48);
        do_req(100000000, 49);
        do_req(400000000, 0);
        do_req(1000000000, 1);
        do_req(3, 64);
        do_req(25000000, 60);
        do_req(25000000, 61);
        do_req(7000000, 63);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(exp_idx_q.size() == 0 && !busy, "R11", "no pending writes after requests", exp_idx_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule